// File: doc/BRIEF.md
# Self-Purging Majority Voter

This block combines the single-bit outputs of a bank of redundant modules into one voted bit. All modules begin in the active set. On every cycle that carries a valid strobe, only the active modules vote. Each active module adds one vote when it drives 1, and a purged module adds nothing. The result is 1 when the count of 1 votes reaches a strict majority of the modules that are still active.

Any active module that disagrees with a decided vote is removed from the active set on the same clock edge that registers the vote. The removal stays in place until a synchronous reset. The majority threshold follows the active count, so the bank keeps masking faults as members drop out.

When the active count is even and the votes split evenly, the block has no majority. It then keeps its previous output, purges nobody and raises a tie flag. The purge mask is available as an output so that surrounding logic can see which modules have been removed.

Top module: `spv_voter`

## Requirements
- R1: While `rst_i` is high at a clock edge, the block registers `purge_mask_o` = 0 (every module active), `voted_o` = 0 and `tie_o` = 0.
- R2: On a valid cycle with A active modules and K of them driving 1, if the vote is not a tie then `voted_o` after that edge is 1 exactly when K >= floor(A/2)+1, and 0 otherwise.
- R3: A purged module (its `purge_mask_o` bit is 1) has weight 0. Its input bit has no effect on the vote, on the tie decision or on the mask.
- R4: On a valid non-tie cycle, every active module whose bit differs from the new voted value gets its `purge_mask_o` bit (bit i belongs to `mod_bits_i[i]`) set at that same edge.
- R5: A set purge bit stays set until reset. No other event clears it.
- R6: On a valid cycle where A is even and K = A/2, `voted_o` keeps its previous value, the mask is unchanged and `tie_o` becomes 1. The next valid non-tie cycle clears `tie_o`.
- R7: On a cycle with `valid_i` low, `voted_o`, `tie_o` and `purge_mask_o` all keep their values, whatever `mod_bits_i` holds.
- R8: The active set never becomes empty. With two or more modules, at least two stay active, because a two-way disagreement is a tie. With a single module, its bit passes straight to `voted_o`.
- R9: Asserting `rst_i` after purges have happened restores every module to active on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Module bits are valid this cycle |
| mod_bits_i | input | N_MOD | One output bit per redundant module |
| voted_o | output | 1 | Registered voted bit |
| purge_mask_o | output | N_MOD | 1 marks a purged module |
| tie_o | output | 1 | Last valid vote had no majority |

## Verification
Unanimous inputs show that the output tracks the data and that nobody is purged. Split inputs with a clear minority show that the threshold is computed over the active set and that the dissenters are purged on the voting edge. Patterns in which only purged modules drive 1 separate weight-0 voting from plain voting over all modules. Even splits on an even active set, repeated down to two survivors, show the hold-and-flag behaviour and that the active set cannot empty. Long random runs with rare per-module flips, idle cycles and periodic resets compare the output, the mask and the flag against a bench model on every cycle.

// File: rtl/spv_pkg.sv
package spv_pkg;
   localparam int unsigned SPV_MAX_MOD = 63;

   function automatic int unsigned spv_cnt_w(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/spv_tally.sv
module spv_tally #(
   parameter int unsigned N_MOD = 5,
   parameter int unsigned CW    = spv_pkg::spv_cnt_w(N_MOD)
) (
   input  logic [N_MOD-1:0] bits_i,
   input  logic [N_MOD-1:0] active_i,
   output logic [CW-1:0]    ones_o,
   output logic [CW-1:0]    act_o
);
   logic [N_MOD-1:0] weighted;

   generate
      for (genvar g = 0; g < N_MOD; g++) begin : g_wt
         assign weighted[g] = bits_i[g] & active_i[g];
      end
   endgenerate

   always_comb begin
      ones_o = '0;
      act_o  = '0;
      for (int i = 0; i < N_MOD; i++) begin
         ones_o = ones_o + CW'(weighted[i]);
         act_o  = act_o + CW'(active_i[i]);
      end
   end
endmodule

// File: rtl/spv_decide.sv
module spv_decide #(
   parameter int unsigned N_MOD = 5,
   parameter int unsigned CW    = spv_pkg::spv_cnt_w(N_MOD)
) (
   input  logic [CW-1:0] ones_i,
   input  logic [CW-1:0] act_i,
   output logic          vote_o,
   output logic          tie_o
);
   localparam int unsigned TW = CW + 1;

   logic [TW-1:0] thresh;
   logic [TW-1:0] half;

   always_comb begin
      half   = TW'(act_i >> 1);
      thresh = half + TW'(1);
      vote_o = (TW'(ones_i) >= thresh);
      tie_o  = (act_i != '0) && !act_i[0] && (TW'(ones_i) == half);
   end
endmodule

// File: rtl/spv_purge_bank.sv
module spv_purge_bank #(
   parameter int unsigned N_MOD = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             commit_i,
   input  logic             vote_i,
   input  logic [N_MOD-1:0] bits_i,
   output logic [N_MOD-1:0] purged_o
);
   generate
      for (genvar g = 0; g < N_MOD; g++) begin : g_cell
         logic dissent;
         assign dissent = commit_i && !purged_o[g] && (bits_i[g] != vote_i);
         always_ff @(posedge clk_i) begin
            if (rst_i)
               purged_o[g] <= 1'b0;
            else if (dissent)
               purged_o[g] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/spv_voter.sv
module spv_voter #(
   parameter int unsigned N_MOD = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             valid_i,
   input  logic [N_MOD-1:0] mod_bits_i,
   output logic             voted_o,
   output logic [N_MOD-1:0] purge_mask_o,
   output logic             tie_o
);
   localparam int unsigned CW = spv_pkg::spv_cnt_w(N_MOD);

   generate
      if (N_MOD < 1 || N_MOD > spv_pkg::SPV_MAX_MOD) begin : g_bad_n
         $error("spv_voter: N_MOD out of range");
      end
   endgenerate

   logic [N_MOD-1:0] active;
   logic [CW-1:0]    ones_cnt;
   logic [CW-1:0]    act_cnt;
   logic             vote_now;
   logic             tie_now;
   logic             commit;

   assign active = ~purge_mask_o;

   spv_tally #(.N_MOD(N_MOD), .CW(CW)) u_tally (
      .bits_i   (mod_bits_i),
      .active_i (active),
      .ones_o   (ones_cnt),
      .act_o    (act_cnt)
   );

   spv_decide #(.N_MOD(N_MOD), .CW(CW)) u_decide (
      .ones_i (ones_cnt),
      .act_i  (act_cnt),
      .vote_o (vote_now),
      .tie_o  (tie_now)
   );

   assign commit = valid_i && !tie_now;

   generate
      if (N_MOD == 1) begin : g_single
         assign purge_mask_o = '0;
      end else begin : g_bank
         spv_purge_bank #(.N_MOD(N_MOD)) u_bank (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .commit_i (commit),
            .vote_i   (vote_now),
            .bits_i   (mod_bits_i),
            .purged_o (purge_mask_o)
         );
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         voted_o <= 1'b0;
         tie_o   <= 1'b0;
      end else if (valid_i) begin
         tie_o <= tie_now;
         if (!tie_now)
            voted_o <= vote_now;
      end
   end
endmodule

// File: rtl/spv_voter_chk.sv
module spv_voter_chk #(
   parameter int unsigned N_MOD = 5
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             valid_i,
   input logic [N_MOD-1:0] mod_bits_i,
   input logic             voted_o,
   input logic [N_MOD-1:0] purge_mask_o,
   input logic             tie_o
);
   localparam int MIN_ACT = (N_MOD >= 2) ? 2 : 1;

   // R7
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_i |=> ($stable(purge_mask_o) && $stable(voted_o) && $stable(tie_o)));

   // R5
   purge_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (($past(purge_mask_o) & ~purge_mask_o) == '0));

   // R8
   min_active_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(~purge_mask_o) >= MIN_ACT);

   // R6
   tie_no_purge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_i && $rose(tie_o)) |-> ($stable(purge_mask_o) && $stable(voted_o)));

   // R3
   purged_no_dissent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_i && !tie_o) |=> ($past(purge_mask_o) == (purge_mask_o & $past(purge_mask_o))));

   // R1
   reset_clean_chk: assert property (@(posedge clk_i)
      rst_i |=> (purge_mask_o == '0 && !voted_o && !tie_o));
endmodule

bind spv_voter spv_voter_chk #(.N_MOD(N_MOD)) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .valid_i      (valid_i),
   .mod_bits_i   (mod_bits_i),
   .voted_o      (voted_o),
   .purge_mask_o (purge_mask_o),
   .tie_o        (tie_o)
);

// File: tb/tb_spv_voter.sv
`timescale 1ns/1ps
module tb_spv_voter;
   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst;
   logic         valid;
   logic [N-1:0] bits;
   logic         voted;
   logic [N-1:0] mask;
   logic         tie;

   int tests_run = 0;
   int tests_bad = 0;
   bit done = 0;

   logic         m_voted;
   logic [N-1:0] m_mask;
   logic         m_tie;

   always #2 clk = ~clk;

   spv_voter #(.N_MOD(N)) dut (
      .clk_i(clk), .rst_i(rst), .valid_i(valid), .mod_bits_i(bits),
      .voted_o(voted), .purge_mask_o(mask), .tie_o(tie)
   );

   function automatic int ones_of(input logic [N-1:0] v);
      int c = 0;
      for (int i = 0; i < N; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic model(input logic r, input logic v, input logic [N-1:0] b);
      logic [N-1:0] act;
      int a, k;
      logic vv;
      if (r) begin
         m_voted = 0; m_mask = '0; m_tie = 0;
         return;
      end
      if (!v) return;
      act = ~m_mask;
      a = ones_of(act);
      k = ones_of(b & act);
      if ((a % 2 == 0) && (2 * k == a)) begin
         m_tie = 1;
      end else begin
         vv = (k >= a / 2 + 1);
         m_mask = m_mask | (act & (b ^ {N{vv}}));
         m_voted = vv;
         m_tie = 0;
      end
   endtask

   task automatic step(input logic r, input logic v, input logic [N-1:0] b, input string tag);
      @(negedge clk);
      rst = r; valid = v; bits = b;
      model(r, v, b);
      @(posedge clk);
      #1;
      tests_run++;
      if (voted !== m_voted || mask !== m_mask || tie !== m_tie) begin
         tests_bad++;
         $display("FAIL %s: voted=%0b mask=%b tie=%0b expected voted=%0b mask=%b tie=%0b",
                  tag, voted, mask, tie, m_voted, m_mask, m_tie);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         tests_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests_run, tests_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      rst = 1; valid = 0; bits = '0;
      m_voted = 0; m_mask = '0; m_tie = 0;
      // R1: reset state
      step(1, 0, '0, "R1 reset");
      step(1, 1, 5'b11111, "R1 reset with data");
      // R2: unanimous ones then zeros
      step(0, 1, 5'b11111, "R2 all ones");
      step(0, 1, 5'b00000, "R2 all zeros");
      // R4: module 0 dissents, purged at the voting edge
      step(0, 1, 5'b11110, "R4 purge module0");
      step(0, 1, 5'b00000, "R2 four active zeros");
      // R3: purged module 0 drives 1, active split 2/2 is a tie
      step(0, 1, 5'b00111, "R3 purged weight zero");
      // R6: the tie flag clears on the next decided vote
      step(0, 1, 5'b11110, "R6 tie clears");
      // R7: idle cycle with dissenting data changes nothing
      step(0, 0, 5'b00001, "R7 idle ignored");
      // R5: purged module agrees again but stays purged
      step(0, 1, 5'b11111, "R5 sticky purge");
      // R4: 3 of 4 active outvote module 4
      step(0, 1, 5'b01110, "R4 purge module4");
      // R2: 2 of 3 active gives 1, module 3 purged
      step(0, 1, 5'b10110, "R2 threshold of three");
      // R8: two active left, disagreement is a tie
      step(0, 1, 5'b00100, "R8 two active tie");
      step(0, 1, 5'b00010, "R8 two active tie again");
      step(0, 1, 5'b00000, "R8 two agree zero");
      // R9: reset restores all modules
      step(1, 0, '0, "R9 reset restores");
      step(0, 1, 5'b00011, "R2 three zeros two ones");

      for (int n = 0; n < 4000; n++) begin
         logic r, v, truth;
         logic [N-1:0] b;
         r = ($urandom % 60) == 0;
         v = ($urandom % 4) != 0;
         truth = 1'($urandom % 2);
         for (int i = 0; i < N; i++)
            b[i] = truth ^ (($urandom % 8) == 0);
         step(r, v, b, "R2/R3/R4/R5/R6/R7 random");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_bad);
      $finish;
   end
endmodule